// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external host read and write a bank of 64 internal 16-bit registers over a four-wire serial link in clock mode 0. The idle clock level is low. The block samples input on the rising serial clock and changes its output on the falling one. The host pulls the active-low select line down, sends one command byte, and then moves two or more data bytes in one direction only. Bits travel most significant first. The host raises the select line to end the transaction. The command byte holds a read flag in bit 7. Bit 6 is unused. Bits 5:0 hold the register address.

The serial pins are not clocked by the system clock. Each one passes through a two-flop synchroniser and an edge detector in the system clock domain. All framing, decode and shifting then runs synchronously. A write pulses a one-cycle write strobe once the full 16-bit word has arrived. A read pulses a one-cycle read strobe; the register file answers one cycle later, and the word is shifted out on the serial output. A payload longer than one word continues at the next address. A configuration input chooses whether the serial output floats or is driven low while the select line is high.

Top module: `spi_regport`

## Requirements
- R1: After reset, no write or read strobe is active, and with cfg_idle_hiz = 1 the serial output is not driven (spi_miso_oe = 0).
- R2: While spi_cs_n is high, the output enable follows the configuration: spi_miso_oe = 0 when cfg_idle_hiz = 1. When cfg_idle_hiz = 0, spi_miso_oe = 1 and spi_miso = 0.
- R3: While spi_cs_n is low, spi_miso_oe = 1 whatever the configuration.
- R4: The first 8 bits after spi_cs_n falls form the command byte. Bit 7 = 1 selects a read and 0 a write. Bits 5:0 are the register address. Bit 6 has no effect.
- R5: In a write, each 16 received data bits form one word, high byte first and MSB first. After the 16th bit is sampled, reg_wr_en pulses for exactly one cycle with that word on reg_wdata and the target on reg_addr.
- R6: If spi_cs_n rises before all 16 bits of a data word have arrived, that partial word is dropped: no write strobe, and the register keeps its value.
- R7: In a read, reg_rd_en pulses for one cycle with the command address. reg_rdata must be valid the cycle after the strobe. The word then appears on spi_miso MSB first, each bit valid at the host's rising edge, starting at the first data bit.
- R8: Each additional 16-bit word in the same transaction addresses the next register, and the address wraps from 63 to 0. This holds for reads and writes.
- R9: A read transaction never asserts reg_wr_en, whatever is on spi_mosi.
- R10: reg_wr_en and reg_rd_en are never high in the same cycle, and each is a single-cycle pulse.
- R11: Raising spi_cs_n in the middle of a byte discards the bit alignment. The next transaction starts with a fresh command byte.
- R12: The system clock runs at least 8 times faster than spi_sclk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_idle_hiz | input | 1 | 1: float the serial output while deselected; 0: drive it low |
| spi_cs_n | input | 1 | Active-low select framing each transaction |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the serial output pad |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_addr | output | 6 | Register address for the current strobe |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data, valid the cycle after reg_rd_en |

## Verification
In a burst read, the serial clock edge that completes one word also issues the read of the next register. The falling edge that follows must load the fetched word, not shift out the old one. The bench provokes this with a two-word read at consecutive addresses and compares all 32 sampled bits with the preloaded values. In the same way, the partial-word abort places the select line rising next to a data edge. The bench judges it by the write strobe count and by the register content, then by a following full write.

// File: rtl/spi_regport_pkg.sv
// Package: shared widths and the command byte layout of the register port.
package spi_regport_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int CMD_W  = 8;

    // Command byte: read flag, unused bit, register address
    typedef struct packed {
        logic              rd;
        logic              unused;
        logic [ADDR_W-1:0] addr;
    } cmd_t;
endpackage

// File: rtl/spi_pin_sync.sv
// spi_pin_sync: two-flop synchroniser plus edge detect per pin.
// Assumes: pins are asynchronous to clk; lvl lags the pin by two clocks,
// rise/fall are one-cycle pulses derived from the synchronised level.
module spi_pin_sync #(
    parameter int           N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [2:0] stg;

        // Shift the pin through two sync stages and one history stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= {3{RST_VAL[g]}};
            else        stg <= {stg[1:0], pin[g]};
        end

        assign lvl[g]  = stg[1];
        assign rise[g] = stg[1] & ~stg[2];
        assign fall[g] = ~stg[1] & stg[2];
    end
endmodule

// File: rtl/spi_frame.sv
// spi_frame: bit counting, command decode, word assembly and register strobes.
// Assumes: cs_s/sclk_rise/mosi_s are synchronised; register file answers a
// read strobe with data valid one cycle later.
module spi_frame
    import spi_regport_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          sclk_rise,
    input  logic          mosi_s,
    output logic          wr_en,
    output logic          rd_en,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    input  logic [DW-1:0] rdata,
    output logic          ld_stb,
    output logic [DW-1:0] ld_data
);
    localparam int CW = $clog2(DW);

    logic [DW-1:0] sh_q;
    logic [DW-1:0] sh_nxt;
    logic [CW-1:0] bit_q;
    logic          in_data_q;
    logic          is_rd_q;
    logic [AW-1:0] nxt_addr_q;
    logic          rd_seen_q;
    cmd_t          cmd;

    assign sh_nxt = {sh_q[DW-2:0], mosi_s};
    assign cmd    = cmd_t'(sh_nxt[CMD_W-1:0]);

    // Frame tracking: count bits, decode the command, emit strobes per word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0; bit_q <= '0; in_data_q <= 1'b0; is_rd_q <= 1'b0;
            nxt_addr_q <= '0; addr <= '0; wdata <= '0;
            wr_en <= 1'b0; rd_en <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            rd_en <= 1'b0;
            if (cs_s) begin
                sh_q <= '0; bit_q <= '0; in_data_q <= 1'b0; is_rd_q <= 1'b0;
            end else if (sclk_rise) begin
                sh_q  <= sh_nxt;
                bit_q <= bit_q + 1'b1;
                if (!in_data_q && bit_q == CW'(CMD_W - 1)) begin
                    in_data_q <= 1'b1;
                    bit_q     <= '0;
                    is_rd_q   <= cmd.rd;
                    if (cmd.rd) begin
                        addr       <= cmd.addr;
                        rd_en      <= 1'b1;
                        nxt_addr_q <= cmd.addr + 1'b1;
                    end else begin
                        nxt_addr_q <= cmd.addr;
                    end
                end else if (in_data_q && bit_q == CW'(DW - 1)) begin
                    bit_q      <= '0;
                    addr       <= nxt_addr_q;
                    nxt_addr_q <= nxt_addr_q + 1'b1;
                    if (is_rd_q) rd_en <= 1'b1;
                    else begin
                        wr_en <= 1'b1;
                        wdata <= sh_nxt;
                    end
                end
            end
        end
    end

    // Capture register-file read data one cycle after the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_seen_q <= 1'b0; ld_stb <= 1'b0; ld_data <= '0;
        end else begin
            rd_seen_q <= rd_en;
            ld_stb    <= rd_seen_q;
            if (rd_seen_q) ld_data <= rdata;
        end
    end

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));
    // R10
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    // R10
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);
    // R6
    wr_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(!cs_s));
    // R9
    no_wr_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !is_rd_q);
endmodule

// File: rtl/spi_miso_shift.sv
// spi_miso_shift: parallel-load shifter that drives serial read data.
// Assumes: loads and shifts happen only on a synchronised falling clock edge;
// a pending load replaces the shift on that edge.
module spi_miso_shift #(
    parameter int DW = spi_regport_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          sclk_fall,
    input  logic          ld_stb,
    input  logic [DW-1:0] ld_data,
    output logic          msb
);
    logic [DW-1:0] sh_q;
    logic          pend_q;

    // Load fetched word or shift left on each falling edge
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            sh_q   <= '0;
            pend_q <= 1'b0;
        end else begin
            if (ld_stb) pend_q <= 1'b1;
            if (sclk_fall) begin
                if (pend_q || ld_stb) begin
                    sh_q   <= ld_data;
                    pend_q <= 1'b0;
                end else begin
                    sh_q <= {sh_q[DW-2:0], 1'b0};
                end
            end
        end
    end

    assign msb = sh_q[DW-1];

    // R7
    miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!cs_s) && !$past(sclk_fall)) |-> $stable(sh_q));
endmodule

// File: rtl/spi_regport.sv
// spi_regport: mode-0 serial slave giving a host access to 16-bit registers.
// Assumes: clk is at least 8x spi_sclk; pad tri-state is built outside from
// spi_miso and spi_miso_oe.
module spi_regport
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_idle_hiz,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int PIN_CS = 2;
    localparam int PIN_CK = 1;
    localparam int PIN_DI = 0;

    logic [2:0]        lvl, rise, fall;
    logic              ld_stb;
    logic [DATA_W-1:0] ld_data;
    logic              msb;

    spi_pin_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .pin({spi_cs_n, spi_sclk, spi_mosi}),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    spi_frame #(.AW(ADDR_W), .DW(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .cs_s(lvl[PIN_CS]), .sclk_rise(rise[PIN_CK]), .mosi_s(lvl[PIN_DI]),
        .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .ld_stb(ld_stb), .ld_data(ld_data)
    );

    spi_miso_shift #(.DW(DATA_W)) u_miso (
        .clk(clk), .rst_n(rst_n),
        .cs_s(lvl[PIN_CS]), .sclk_fall(fall[PIN_CK]),
        .ld_stb(ld_stb), .ld_data(ld_data), .msb(msb)
    );

    // Output enable follows select directly; idle level chosen by config
    assign spi_miso_oe = ~spi_cs_n | ~cfg_idle_hiz;
    assign spi_miso    = ~spi_cs_n & msb;
endmodule

// File: tb/sim_spi_regport.sv
module sim_spi_regport;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;   // serial half period in system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_idle_hiz = 1'b1;
    logic        spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe;
    logic        reg_wr_en, reg_rd_en;
    logic [5:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;

    int checks = 0, errors = 0;
    int wr_cnt = 0, both_cnt = 0, wr_long = 0, rd_long = 0;
    logic [15:0] mem [64];
    logic wr_d = 1'b0, rd_d = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regport u0 (
        .clk(clk), .rst_n(rst_n), .cfg_idle_hiz(cfg_idle_hiz),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Register file model with one-cycle read latency, plus strobe monitors
    always @(posedge clk) begin
        if (reg_wr_en) begin mem[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1; end
        if (reg_rd_en) reg_rdata <= mem[reg_addr];
        if (reg_wr_en && reg_rd_en) both_cnt <= both_cnt + 1;
        if (reg_wr_en && wr_d) wr_long <= wr_long + 1;
        if (reg_rd_en && rd_d) rd_long <= rd_long + 1;
        wr_d <= reg_wr_en;
        rd_d <= reg_rd_en;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic r);
        spi_mosi = b;
        repeat (HALF) @(negedge clk);
        r = spi_miso;
        spi_sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) sbit(tx[i], rx[i]);
    endtask

    task automatic cs_on();
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    // One-word transaction; returns the word seen on spi_miso
    task automatic xfer(input logic [7:0] cmd, input logic [15:0] wd, output logic [15:0] rd);
        logic [7:0] d;
        cs_on();
        sbyte(cmd, d);
        sbyte(wd[15:8], rd[15:8]);
        sbyte(wd[7:0], rd[7:0]);
        cs_off();
    endtask

    // {cmd byte, data}: cmd bit7 read, bit6 unused, bits5:0 address
    localparam logic [23:0] VEC [7] = '{
        24'h05_A55A, 24'h6A_0F0F, 24'h00_C3C3, 24'h3F_8001,
        24'h85_A55A, 24'hEA_0F0F, 24'hBF_8001
    };

    initial begin
        logic [15:0] rw;
        logic [7:0]  rb;
        int          w0;
        for (int i = 0; i < 64; i++) mem[i] = 16'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        chk(!reg_wr_en && !reg_rd_en, "R1 strobes idle", {reg_wr_en, reg_rd_en}, 0);
        chk(spi_miso_oe == 1'b0, "R1 output floats", spi_miso_oe, 0);

        // R2/R3: idle drive option and drive during a frame
        cfg_idle_hiz = 1'b0;
        @(negedge clk);
        chk(spi_miso_oe && !spi_miso, "R2 idle driven low", {spi_miso_oe, spi_miso}, 2);
        cfg_idle_hiz = 1'b1;
        @(negedge clk);
        chk(!spi_miso_oe, "R2 idle floats", spi_miso_oe, 0);
        spi_cs_n = 1'b0;
        @(negedge clk);
        chk(spi_miso_oe, "R3 driven while selected", spi_miso_oe, 1);
        spi_cs_n = 1'b1;
        repeat (6) @(negedge clk);

        // R4/R5/R7/R9: vector table walk
        foreach (VEC[k]) begin
            w0 = wr_cnt;
            xfer(VEC[k][23:16], VEC[k][23] ? 16'hFFFF : VEC[k][15:0], rw);
            if (VEC[k][23]) begin
                chk(rw == VEC[k][15:0], "R7 read word", rw, VEC[k][15:0]);
                chk(wr_cnt == w0, "R9 no write on read", wr_cnt - w0, 0);
            end else begin
                chk(mem[VEC[k][21:16]] == VEC[k][15:0], "R5 write word",
                    mem[VEC[k][21:16]], VEC[k][15:0]);
                chk(wr_cnt == w0 + 1, "R4 single write", wr_cnt - w0, 1);
            end
        end

        // R6/R11: aborted write mid-byte, then a clean write
        mem[7] = 16'h1111;
        w0 = wr_cnt;
        cs_on();
        sbyte(8'h07, rb);
        sbyte(8'h99, rb);
        for (int i = 0; i < 4; i++) sbit(1'b1, rb[0]);
        cs_off();
        chk(wr_cnt == w0, "R6 partial dropped", wr_cnt - w0, 0);
        chk(mem[7] == 16'h1111, "R6 register kept", mem[7], 16'h1111);
        xfer(8'h07, 16'h2222, rw);
        chk(mem[7] == 16'h2222, "R11 fresh frame", mem[7], 16'h2222);

        // R8: burst write wrapping 62,63,0
        cs_on();
        sbyte(8'h3E, rb);
        sbyte(8'h11, rb); sbyte(8'h22, rb);
        sbyte(8'h33, rb); sbyte(8'h44, rb);
        sbyte(8'h55, rb); sbyte(8'h66, rb);
        cs_off();
        chk(mem[62] == 16'h1122, "R8 burst word0", mem[62], 16'h1122);
        chk(mem[63] == 16'h3344, "R8 burst word1", mem[63], 16'h3344);
        chk(mem[0] == 16'h5566, "R8 wrap to 0", mem[0], 16'h5566);

        // R8/R7: burst read of two words
        mem[20] = 16'hBEEF; mem[21] = 16'h1234;
        cs_on();
        sbyte(8'h94, rb);
        sbyte(8'h00, rw[15:8]); sbyte(8'h00, rw[7:0]);
        chk(rw == 16'hBEEF, "R7 burst read word0", rw, 16'hBEEF);
        sbyte(8'hFF, rw[15:8]); sbyte(8'hFF, rw[7:0]);
        chk(rw == 16'h1234, "R8 burst read word1", rw, 16'h1234);
        cs_off();

        // R10: strobe exclusivity and width over the whole run
        chk(both_cnt == 0, "R10 strobes exclusive", both_cnt, 0);
        chk(wr_long == 0 && rd_long == 0, "R10 single-cycle pulses", wr_long + rd_long, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog; R12 clock ratio is fixed by HALF
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule